// File: doc/BRIEF.md
# Configurable Video Pixel Port Formatter

This block sits between an internal video pipeline and a 20-bit output pixel port. Once every four full-rate clock cycles it takes in one 4:2:2 macropixel (a blue-difference chroma sample, a first luma sample, a red-difference chroma sample and a second luma sample, each 10 bits wide). It then lays those samples out on the port according to a 4-bit format code. The two narrow formats interleave chroma and luma on the top lane, one sample per full-rate cycle. The two wide formats put a luma sample and a chroma sample side by side, and each pair is held for two full-rate cycles.

For every port bit the block drives a data bit and an output enable. Bits that the selected format does not use are tri-stated and read as zero. A swap control reverses the order of the two chroma samples. The block produces a half-rate clock that stays in phase with the luma/chroma pairs. A clock select decides whether the primary clock pin carries the full-rate or the half-rate clock. A polarity control inverts both clock pins. Format codes other than the four defined ones are rejected: the whole port is tri-stated and an error flag is raised.

Top module: `pixel_port_fmt`

## Requirements
- R1: While reset is asserted, and until the first output slot is loaded, every output enable is 0, every data bit is 0 and the error flag is 0.
- R2: `take_o` is high for one cycle in every four. The macropixel inputs and `swap_i` are sampled at the rising edge that ends a high `take_o` cycle. The four output slots 0..3 of that macropixel appear in the four cycles that follow that edge.
- R3: Format 4'b0000 drives slots C0, Y0, C1, Y1 as full 10-bit samples on bits 19:10 with enables high there. Bits 9:0 are tri-stated.
- R4: Format 4'b0011 drives the same slot order on bits 19:12, using the upper 8 bits of each sample (truncated, not rounded). Bits 11:0 are tri-stated.
- R5: Format 4'b0001 drives luma on bits 19:10 and chroma on bits 9:0, with all 20 enables high. Slots 0 and 1 carry the pair (Y0, C0) and slots 2 and 3 carry (Y1, C1), so each word is held for two cycles.
- R6: Format 4'b0010 drives the upper 8 bits of luma on bits 19:12 and the upper 8 bits of chroma on bits 9:2. Bits 11:10 and 1:0 are tri-stated.
- R7: Any other format code (4'b0100 through 4'b1111) tri-states all 20 bits, forces the data to 0 and sets `fmt_err_o`.
- R8: With the swap control at 0, C0 is the blue-difference sample and C1 is the red-difference sample. With the swap control at 1 the two are exchanged.
- R9: `fmt_i` is taken only at the edges that load slot 0 or slot 2. A change applied between those edges does not affect slots 1 or 3.
- R10: `hclk_pin_o` is high during slots 0 and 2 and low during slots 1 and 3, XORed with `clk_inv_i`.
- R11: When `clk_sel_i` is 3'b101, `clk_pin_o` carries the half-rate clock. For any other value it carries the full-rate clock. Both clock choices are XORed with `clk_inv_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Full-rate pixel clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| take_o | output | 1 | High in the cycle whose closing edge samples a macropixel |
| cb_i | input | 10 | Blue-difference chroma sample |
| y0_i | input | 10 | First luma sample |
| cr_i | input | 10 | Red-difference chroma sample |
| y1_i | input | 10 | Second luma sample |
| fmt_i | input | 4 | Output format code |
| swap_i | input | 1 | Chroma order swap |
| clk_sel_i | input | 3 | Primary clock pin source select |
| clk_inv_i | input | 1 | Clock polarity invert |
| pp_data_o | output | 20 | Pixel port data |
| pp_oe_o | output | 20 | Per-bit output enable, 1 drives the pin |
| fmt_err_o | output | 1 | Invalid format code in use |
| clk_pin_o | output | 1 | Primary clock pin |
| hclk_pin_o | output | 1 | Half-rate clock pin |

## Verification
The hardest case to reach from the ports is a format change that arrives in the middle of a macropixel. Only a change timed to land between the slot-0 and slot-1 edges shows whether the block waits for the pair boundary. The bench steps through every format code with both swap settings and several sample patterns. It also runs groups in which `fmt_i` is changed right after slot 0 is observed. For those groups it expects slot 1 under the old format and slots 2 and 3 under the new one.

// File: rtl/ppf_pkg.sv
package ppf_pkg;
  typedef enum logic [3:0] {
    FMT_N10 = 4'b0000,
    FMT_W20 = 4'b0001,
    FMT_W16 = 4'b0010,
    FMT_N8  = 4'b0011
  } ppf_fmt_e;

  localparam logic [2:0] CLKSEL_HALF = 3'b101;

  function automatic logic fmt_is_wide(input logic [3:0] f);
    return (f == FMT_W20) || (f == FMT_W16);
  endfunction
endpackage

// File: rtl/ppf_phase.sv
module ppf_phase #(
  parameter int SLOTS = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  output logic [$clog2(SLOTS)-1:0] ph_o,
  output logic                     take_o,
  output logic                     hclk_o,
  output logic                     started_o
);
  localparam int PHW = $clog2(SLOTS);
  localparam logic [PHW-1:0] LAST = PHW'(SLOTS - 1);

  logic [PHW-1:0] ph_q;
  logic           hclk_q, started_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ph_q      <= '0;
      hclk_q    <= 1'b0;
      started_q <= 1'b0;
    end else begin
      ph_q      <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
      hclk_q    <= ~ph_q[0];
      started_q <= 1'b1;
    end
  end

  assign ph_o      = ph_q;
  assign take_o    = (ph_q == '0);
  assign hclk_o    = hclk_q;
  assign started_o = started_q;

  a_r2_take_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);
  a_r2_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == LAST) |=> take_o);
  a_r10_hclk_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> (hclk_q != $past(hclk_q)));
endmodule

// File: rtl/ppf_lane_map.sv
module ppf_lane_map
  import ppf_pkg::*;
#(
  parameter int SW = 10,
  parameter int NW = 8
) (
  input  logic [3:0]      fmt_i,
  input  logic [1:0]      slot_i,
  input  logic [SW-1:0]   y0_i,
  input  logic [SW-1:0]   c0_i,
  input  logic [SW-1:0]   y1_i,
  input  logic [SW-1:0]   c1_i,
  output logic [2*SW-1:0] data_o,
  output logic [2*SW-1:0] oe_o,
  output logic            err_o
);
  localparam int PW   = 2 * SW;
  localparam int PADW = SW - NW;

  function automatic logic [NW-1:0] trunc(input logic [SW-1:0] s);
    return s[SW-1 -: NW];
  endfunction

  logic [SW-1:0] y_sel, c_sel, smp;

  always_comb begin
    y_sel = slot_i[1] ? y1_i : y0_i;
    c_sel = slot_i[1] ? c1_i : c0_i;
    smp   = slot_i[0] ? y_sel : c_sel;
  end

  always_comb begin
    data_o = '0;
    oe_o   = '0;
    err_o  = 1'b0;
    case (fmt_i)
      FMT_N10: begin
        data_o = {smp, {SW{1'b0}}};
        oe_o   = {{SW{1'b1}}, {SW{1'b0}}};
      end
      FMT_N8: begin
        data_o = {trunc(smp), {(PW-NW){1'b0}}};
        oe_o   = {{NW{1'b1}}, {(PW-NW){1'b0}}};
      end
      FMT_W20: begin
        data_o = {y_sel, c_sel};
        oe_o   = {PW{1'b1}};
      end
      FMT_W16: begin
        data_o = {trunc(y_sel), {PADW{1'b0}}, trunc(c_sel), {PADW{1'b0}}};
        oe_o   = {{NW{1'b1}}, {PADW{1'b0}}, {NW{1'b1}}, {PADW{1'b0}}};
      end
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/pixel_port_fmt.sv
module pixel_port_fmt
  import ppf_pkg::*;
#(
  parameter int SW = 10,
  parameter int NW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic            take_o,
  input  logic [SW-1:0]   cb_i,
  input  logic [SW-1:0]   y0_i,
  input  logic [SW-1:0]   cr_i,
  input  logic [SW-1:0]   y1_i,
  input  logic [3:0]      fmt_i,
  input  logic            swap_i,
  input  logic [2:0]      clk_sel_i,
  input  logic            clk_inv_i,
  output logic [2*SW-1:0] pp_data_o,
  output logic [2*SW-1:0] pp_oe_o,
  output logic            fmt_err_o,
  output logic            clk_pin_o,
  output logic            hclk_pin_o
);
  localparam int PW = 2 * SW;

  logic [1:0]    ph;
  logic          take, hclk_q, started;
  logic [SW-1:0] y0_q, c0_q, y1_q, c1_q;
  logic [SW-1:0] y0_s, c0_s, y1_s, c1_s;
  logic [3:0]    fmt_q, fmt_eff;
  logic [1:0]    slot_q;
  logic [PW-1:0] data_d, oe_d, data_q, oe_q;
  logic          err_d, err_q;
  logic          pair_edge;

  ppf_phase #(.SLOTS(4)) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ph_o     (ph),
    .take_o   (take),
    .hclk_o   (hclk_q),
    .started_o(started)
  );

  // Bypass the capture registers on the loading edge so slot 0 is not delayed.
  always_comb begin
    if (take) begin
      y0_s = y0_i;
      y1_s = y1_i;
      c0_s = swap_i ? cr_i : cb_i;
      c1_s = swap_i ? cb_i : cr_i;
    end else begin
      y0_s = y0_q;
      y1_s = y1_q;
      c0_s = c0_q;
      c1_s = c1_q;
    end
  end

  assign pair_edge = ~ph[0];
  assign fmt_eff   = pair_edge ? fmt_i : fmt_q;

  ppf_lane_map #(.SW(SW), .NW(NW)) u_map (
    .fmt_i (fmt_eff),
    .slot_i(ph),
    .y0_i  (y0_s),
    .c0_i  (c0_s),
    .y1_i  (y1_s),
    .c1_i  (c1_s),
    .data_o(data_d),
    .oe_o  (oe_d),
    .err_o (err_d)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      y0_q   <= '0;
      c0_q   <= '0;
      y1_q   <= '0;
      c1_q   <= '0;
      fmt_q  <= FMT_N8;
      slot_q <= '0;
      data_q <= '0;
      oe_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      y0_q   <= y0_s;
      c0_q   <= c0_s;
      y1_q   <= y1_s;
      c1_q   <= c1_s;
      fmt_q  <= fmt_eff;
      slot_q <= ph;
      data_q <= data_d;
      oe_q   <= oe_d;
      err_q  <= err_d;
    end
  end

  logic fclk_out, hclk_out;
  assign fclk_out   = clk_i ^ clk_inv_i;
  assign hclk_out   = hclk_q ^ clk_inv_i;
  assign clk_pin_o  = (clk_sel_i == CLKSEL_HALF) ? hclk_out : fclk_out;
  assign hclk_pin_o = hclk_out;
  assign take_o     = take;
  assign pp_data_o  = data_q;
  assign pp_oe_o    = oe_q;
  assign fmt_err_o  = err_q;

  a_r7_err_tristate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_err_o |-> (pp_oe_o == '0 && pp_data_o == '0));
  a_r9_fmt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q[0] |-> $stable(fmt_q));
  a_r5_wide_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && slot_q[0] && fmt_is_wide(fmt_q)) |-> $stable(pp_data_o));
  a_r10_hclk_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && slot_q[0]) |-> !hclk_q);
endmodule

// File: tb/pixel_port_fmt_tb.sv
module pixel_port_fmt_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        take;
  logic [9:0]  cb = '0, y0 = '0, cr = '0, y1 = '0;
  logic [3:0]  fmt = 4'b0011;
  logic        swap = 1'b0;
  logic [2:0]  csel = 3'b000;
  logic        cinv = 1'b0;
  logic [19:0] data, oe;
  logic        err, cpin, hpin;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_port_fmt u_dut (
    .clk_i(clk), .rst_ni(rst_n), .take_o(take),
    .cb_i(cb), .y0_i(y0), .cr_i(cr), .y1_i(y1),
    .fmt_i(fmt), .swap_i(swap), .clk_sel_i(csel), .clk_inv_i(cinv),
    .pp_data_o(data), .pp_oe_o(oe), .fmt_err_o(err),
    .clk_pin_o(cpin), .hclk_pin_o(hpin)
  );

  task automatic chk(input string tag, input logic [19:0] got, input logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // Expected port word, computed arithmetically from the requirements.
  task automatic expect_slot(input int f, input bit sw, input int s,
                             input int vcb, input int vy0, input int vcr, input int vy1,
                             output int d, output int e, output bit er);
    int c, y, smp;
    c   = (s < 2) ? (sw ? vcr : vcb) : (sw ? vcb : vcr);
    y   = (s < 2) ? vy0 : vy1;
    smp = (s % 2 == 1) ? y : c;
    d = 0; e = 0; er = 0;
    case (f)
      0: begin d = smp * 1024;                   e = 1023 * 1024; end
      3: begin d = (smp / 4) * 4096;             e = 255 * 4096; end
      1: begin d = y * 1024 + c;                 e = 1048575; end
      2: begin d = (y / 4) * 4096 + (c / 4) * 4; e = 255 * 4096 + 255 * 4; end
      default: er = 1;
    endcase
  endtask

  // Entered at a negedge with take high; ends at the next such negedge.
  task automatic run_group(input int fa, input int fb, input bit sw,
                           input int vcb, input int vy0, input int vcr, input int vy1,
                           input bit inv, input int sel);
    int d, e, f;
    bit er;
    chk("R2 take at group start", {19'd0, take}, 20'd1);
    fmt = 4'(fa); swap = sw; cinv = inv; csel = 3'(sel);
    cb = 10'(vcb); y0 = 10'(vy0); cr = 10'(vcr); y1 = 10'(vy1);
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      f = (s < 2) ? fa : fb;
      expect_slot(f, sw, s, vcb, vy0, vcr, vy1, d, e, er);
      // Scramble inputs after the capture edge: they must not leak (R2).
      cb = ~cb; y0 = y0 + 10'd7; swap = ~sw;
      chk($sformatf("R3 R4 R5 R6 R8 data fmt%0d/%0d s%0d", fa, fb, s), data, 20'(d));
      chk($sformatf("R3 R4 R5 R6 oe fmt%0d s%0d", f, s), oe, 20'(e));
      chk($sformatf("R7 err fmt%0d", f), {19'd0, err}, {19'd0, er});
      chk("R10 hclk pin", {19'd0, hpin}, {19'd0, ((s % 2 == 0) ? 1'b1 : 1'b0) ^ inv});
      chk("R11 clk pin", {19'd0, cpin},
          {19'd0, (sel == 5) ? (((s % 2 == 0) ? 1'b1 : 1'b0) ^ inv) : inv});
      chk("R2 take position", {19'd0, take}, {19'd0, (s == 3)});
      if (s == 0) fmt = 4'(fb);   // R9: change lands between slot 0 and slot 1 edges
      if (s == 2) fmt = 4'(fb ^ 4'hF);  // R9: mid-pair change must not reach slot 3
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset oe", oe, 20'd0);
    chk("R1 reset data", data, 20'd0);
    chk("R1 reset err", {19'd0, err}, 20'd0);
    rst_n = 1'b1;
    chk("R1 oe before first slot", oe, 20'd0);
    for (int f = 0; f < 16; f++)
      for (int sw = 0; sw < 2; sw++)
        for (int p = 0; p < 3; p++) begin
          int a, b, c, d;
          a = (p == 0) ? 1023 : (p == 1) ? 0 : (f * 61 + 5) % 1024;
          b = (p == 0) ? 0 : (p == 1) ? 1023 : (f * 37 + 513) % 1024;
          c = (p == 2) ? (sw * 300 + 2) % 1024 : 682;
          d = (p == 2) ? 1021 - f : 341;
          run_group(f, f, sw[0], a, b, c, d, p[0], (p == 1) ? 5 : f % 8);
        end
    // R9: format changes right after slot 0 for every valid pair of formats.
    for (int fa = 0; fa < 4; fa++)
      for (int fb = 0; fb < 5; fb++)
        run_group(fa, (fb == 4) ? 9 : fb, fa[0], 901, 77, 258, 640, fb[0], 5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule